// File: doc/BRIEF.md
# Fetch Thread Selector

This block chooses, every clock cycle, which of several hardware threads supplies instructions to the fetch stage of a multithreaded core. The thread that wins is reported both as a one-hot vector and as an index, with a valid bit. The selection is combinational from the current inputs and a small amount of registered history: the last granted thread and whether the previous cycle produced a grant.

A two-bit policy input picks the base rule at run time. In rotating mode, threads are taken in turn, one per cycle, skipping threads that are not ready. In sticky mode, the last thread stays selected until it reports a long-latency stall; the selector then moves to the next usable thread and stays there. In balance mode, the selector prefers the ready thread that has the fewest instructions in flight. On top of any of these rules, a preferred-thread override can be enabled so that one chosen thread loses as little fetch bandwidth as possible.

The history is kept by a state machine. It has these states:
- `S_IDLE`: after reset, or after a cycle with no grant.
- `S_ROTATE`: the last grant came from the rotating rule.
- `S_HOLD`: the last grant came from the sticky rule.
- `S_BALANCE`: the last grant came from the balance rule.
- `S_PRIO`: the last grant came from the override.

Each cycle the machine moves to the state of whichever rule produced that cycle's grant. If no thread was granted, it moves to `S_IDLE`. Any state can move to any other state.

Top module: `fetch_thread_sel`

## Requirements
- R1: After reset the last-granted pointer is thread N-1 and the state is `S_IDLE`. With no ready thread, `grant_vld` and `grant_oh` are 0. In rotating mode with all threads ready, the first grant goes to thread 0.
- R2: When the active rule finds no qualifying thread, `grant_vld` is 0, `grant_oh` is all zero and `grant_idx` is 0.
- R3: With `mode` = 0 (rotating), the grant goes to the first ready thread in the cyclic order last+1, last+2, …, last. The last-granted thread is therefore chosen again only when it is the only ready thread.
- R4: With `mode` = 1 (sticky), if the previous cycle produced a grant and the last-granted thread is ready with `long_stall` low, that thread is granted again.
- R5: With `mode` = 1, otherwise the grant goes to the first thread that is ready with `long_stall` low, searching cyclically from last+1. A thread with `long_stall` high is never granted by this rule.
- R6: With `mode` = 2 (balance), the grant goes to the ready thread with the smallest in-flight count. Ties go to the tied thread met first in the cyclic order from last+1. Thread t's count is `inflight[t*CNT_W +: CNT_W]`.
- R7: When `prio_en` is high and thread `prio_id` is ready, that thread is granted, whatever the mode and whatever its stall flag.
- R8: `grant_oh` has at most one bit set. When `grant_vld` is high, `grant_oh` equals 1 << `grant_idx`.
- R9: `mode` = 3 is reserved and behaves exactly as rotating mode.
- R10: In rotating and balance modes, `long_stall` has no effect on the grant.
- R11: Every grant, under every rule, updates the last-granted pointer. A cycle without a grant leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Policy: 0 rotate, 1 sticky, 2 balance, 3 reserved (rotate) |
| ready | input | N | Per-thread ready to fetch |
| long_stall | input | N | Per-thread long-latency stall flag |
| inflight | input | N*CNT_W | Per-thread in-flight instruction counts, thread t in bits t*CNT_W +: CNT_W |
| prio_en | input | 1 | Enable preferred-thread override |
| prio_id | input | IDX_W | Preferred thread index |
| grant_vld | output | 1 | A thread is granted this cycle |
| grant_oh | output | N | One-hot grant |
| grant_idx | output | IDX_W | Encoded grant |

## Verification
The grant outputs depend combinationally on the current inputs, so each result is due in the same cycle as its stimulus. The history (last pointer and previous-valid flag) changes one cycle later, at the next rising edge. The bench applies inputs on the falling edge and compares a quarter period later, before the rising edge. It then advances its own pointer model, which is computed from the requirements, so that it changes at the same edge as the design's registers. The sweeps step pseudo-random ready, stall and count patterns through every mode, with the override both off and on, so that mode changes also exercise the sticky rule starting from another rule's history.

// File: rtl/fts_pkg.sv
package fts_pkg;
    typedef enum logic [1:0] {
        MODE_ROTATE  = 2'd0,
        MODE_STICKY  = 2'd1,
        MODE_BALANCE = 2'd2,
        MODE_RSVD    = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ROTATE,
        S_HOLD,
        S_BALANCE,
        S_PRIO
    } sel_state_e;
endpackage

// File: rtl/fts_rr_pick.sv
module fts_rr_pick #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] base,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = (int'(base) + k) % N;
            if (!found && req[j]) begin
                found = 1'b1;
                idx   = IDX_W'(j);
            end
        end
    end
endmodule

// File: rtl/fts_min_pick.sv
module fts_min_pick #(
    parameter int N     = 4,
    parameter int CNT_W = 3,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]       req,
    input  logic [N*CNT_W-1:0] cnt,
    input  logic [IDX_W-1:0]   base,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        logic [CNT_W-1:0] best;
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = (int'(base) + k) % N;
            if (req[j] && (!found || cnt[j*CNT_W +: CNT_W] < best)) begin
                found = 1'b1;
                idx   = IDX_W'(j);
                best  = cnt[j*CNT_W +: CNT_W];
            end
        end
    end
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel
    import fts_pkg::*;
#(
    parameter int N     = 4,
    parameter int CNT_W = 3,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode,
    input  logic [N-1:0]       ready,
    input  logic [N-1:0]       long_stall,
    input  logic [N*CNT_W-1:0] inflight,
    input  logic               prio_en,
    input  logic [IDX_W-1:0]   prio_id,
    output logic               grant_vld,
    output logic [N-1:0]       grant_oh,
    output logic [IDX_W-1:0]   grant_idx
);
    localparam logic [IDX_W-1:0] LAST_RST = IDX_W'(N - 1);

    sel_state_e       state_q, state_d;
    logic [IDX_W-1:0] last_q;
    logic [N-1:0]     usable;
    logic             rot_found, stk_found, bal_found;
    logic [IDX_W-1:0] rot_idx, stk_idx, bal_idx;
    logic             hold_ok, prio_hit;

    assign usable   = ready & ~long_stall;
    assign hold_ok  = (state_q != S_IDLE) && usable[last_q];
    assign prio_hit = prio_en && ready[prio_id];

    fts_rr_pick #(.N(N), .IDX_W(IDX_W)) u_rot (
        .req(ready), .base(last_q), .found(rot_found), .idx(rot_idx)
    );

    fts_rr_pick #(.N(N), .IDX_W(IDX_W)) u_stk (
        .req(usable), .base(last_q), .found(stk_found), .idx(stk_idx)
    );

    fts_min_pick #(.N(N), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_bal (
        .req(ready), .cnt(inflight), .base(last_q),
        .found(bal_found), .idx(bal_idx)
    );

    // Decision: which rule grants this cycle, and the next state.
    always_comb begin
        grant_vld = 1'b0;
        grant_idx = '0;
        state_d   = S_IDLE;
        if (prio_hit) begin
            grant_vld = 1'b1;
            grant_idx = prio_id;
            state_d   = S_PRIO;
        end else begin
            unique case (mode_e'(mode))
                MODE_STICKY: begin
                    if (hold_ok) begin
                        grant_vld = 1'b1;
                        grant_idx = last_q;
                    end else begin
                        grant_vld = stk_found;
                        grant_idx = stk_idx;
                    end
                    state_d = grant_vld ? S_HOLD : S_IDLE;
                end
                MODE_BALANCE: begin
                    grant_vld = bal_found;
                    grant_idx = bal_idx;
                    state_d   = bal_found ? S_BALANCE : S_IDLE;
                end
                MODE_ROTATE, MODE_RSVD: begin
                    grant_vld = rot_found;
                    grant_idx = rot_idx;
                    state_d   = rot_found ? S_ROTATE : S_IDLE;
                end
            endcase
        end
    end

    // Output decode.
    always_comb begin
        grant_oh = '0;
        if (grant_vld) grant_oh[grant_idx] = 1'b1;
    end

    // State and history registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            last_q  <= LAST_RST;
        end else begin
            state_q <= state_d;
            if (grant_vld) last_q <= grant_idx;
        end
    end
endmodule

// File: rtl/fetch_thread_sel_chk.sv
module fetch_thread_sel_chk #(
    parameter int N     = 4,
    parameter int CNT_W = 3,
    parameter int IDX_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         mode,
    input logic [N-1:0]       ready,
    input logic [N-1:0]       long_stall,
    input logic [N*CNT_W-1:0] inflight,
    input logic               prio_en,
    input logic [IDX_W-1:0]   prio_id,
    input logic               grant_vld,
    input logic [N-1:0]       grant_oh,
    input logic [IDX_W-1:0]   grant_idx
);
    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // R8
    oh_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_oh));

    // R8
    oh_matches_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> (grant_oh[grant_idx] && $countones(grant_oh) == 1));

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_vld |-> (grant_oh == '0 && grant_idx == '0));

    // R3
    grant_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> ready[grant_idx]);

    // R7
    prio_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_en && ready[prio_id]) |-> (grant_vld && grant_idx == prio_id));

    // R5
    sticky_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && !(prio_en && ready[prio_id]) && grant_vld)
            |-> !long_stall[grant_idx]);

    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(grant_vld) && mode == 2'd1 && !(prio_en && ready[prio_id])
         && ready[$past(grant_idx)] && !long_stall[$past(grant_idx)])
            |-> (grant_vld && grant_idx == $past(grant_idx)));

    // R2
    empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready == '0) |-> !grant_vld);
endmodule

bind fetch_thread_sel fetch_thread_sel_chk #(.N(N), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ready(ready), .long_stall(long_stall),
    .inflight(inflight), .prio_en(prio_en), .prio_id(prio_id),
    .grant_vld(grant_vld), .grant_oh(grant_oh), .grant_idx(grant_idx)
);

// File: tb/fetch_thread_sel_tb.sv
module fetch_thread_sel_tb;
    localparam int N     = 4;
    localparam int CNT_W = 3;
    localparam int IDX_W = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [1:0]         mode = '0;
    logic [N-1:0]       ready = '0;
    logic [N-1:0]       long_stall = '0;
    logic [N*CNT_W-1:0] inflight = '0;
    logic               prio_en = 1'b0;
    logic [IDX_W-1:0]   prio_id = '0;
    logic               grant_vld;
    logic [N-1:0]       grant_oh;
    logic [IDX_W-1:0]   grant_idx;

    int checks = 0;
    int errors = 0;
    int last_m = N - 1;
    bit prev_m = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    fetch_thread_sel #(.N(N), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .ready(ready),
        .long_stall(long_stall), .inflight(inflight), .prio_en(prio_en),
        .prio_id(prio_id), .grant_vld(grant_vld), .grant_oh(grant_oh),
        .grant_idx(grant_idx)
    );

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic [15:0] nxt(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference model from the requirements; -1 means no grant.
    function automatic int expect_idx(output string tag);
        int e;
        int best;
        e = -1;
        best = 0;
        if (prio_en && ready[prio_id]) begin
            tag = "R7";
            return int'(prio_id);
        end
        if (mode == 2'd1) begin
            if (prev_m && ready[last_m] && !long_stall[last_m]) begin
                tag = "R4";
                return last_m;
            end
            tag = "R5";
            for (int k = 1; k <= N; k++) begin
                int j = (last_m + k) % N;
                if (e < 0 && ready[j] && !long_stall[j]) e = j;
            end
        end else if (mode == 2'd2) begin
            tag = (long_stall != 0) ? "R6/R10" : "R6";
            for (int k = 1; k <= N; k++) begin
                int j = (last_m + k) % N;
                int c = int'(inflight[j*CNT_W +: CNT_W]);
                if (ready[j] && (e < 0 || c < best)) begin
                    e = j;
                    best = c;
                end
            end
        end else begin
            tag = (mode == 2'd3) ? "R9" : ((long_stall != 0) ? "R3/R10" : "R3");
            for (int k = 1; k <= N; k++) begin
                int j = (last_m + k) % N;
                if (e < 0 && ready[j]) e = j;
            end
        end
        if (e < 0) tag = "R2";
        return e;
    endfunction

    // Inputs set on the falling edge; compared before the rising edge.
    task automatic step(input logic [1:0] m, input logic [N-1:0] rdy,
                        input logic [N-1:0] stl, input logic [N*CNT_W-1:0] cnt,
                        input logic pe, input logic [IDX_W-1:0] pid);
        string tag;
        int e;
        @(negedge clk);
        mode = m; ready = rdy; long_stall = stl; inflight = cnt;
        prio_en = pe; prio_id = pid;
        #5;
        e = expect_idx(tag);
        check(tag, grant_vld ? int'(grant_idx) : -1, e);
        check("R8", int'(grant_oh), (e < 0) ? 0 : (1 << e));
        // R11: pointer advances on any grant
        if (e >= 0) last_m = e;
        prev_m = (e >= 0);
    endtask

    initial begin
        #35;
        // R1: reset state outputs
        #5;
        check("R1", int'(grant_vld), 0);
        check("R1", int'(grant_oh), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(2'd0, 4'b0000, 4'b0000, '0, 1'b0, 2'd0);
        // R1: first rotating grant after reset is thread 0
        step(2'd0, 4'b1111, 4'b0000, '0, 1'b0, 2'd0);
        check("R1", last_m, 0);
        // R3: only the last thread ready gets it again
        step(2'd0, 4'b0001, 4'b0000, '0, 1'b0, 2'd0);
        // R4/R5 directed: hold thread 0, then stall moves to 2, then holds 2
        step(2'd1, 4'b1111, 4'b0000, '0, 1'b0, 2'd0);
        step(2'd1, 4'b1101, 4'b0001, '0, 1'b0, 2'd0);
        check("R5", int'(grant_idx), 2);
        step(2'd1, 4'b1111, 4'b0000, '0, 1'b0, 2'd0);
        check("R4", int'(grant_idx), 2);
        // R6 tie: all counts equal, RR from last+1 = 3
        step(2'd2, 4'b1111, 4'b0000, {4{3'd5}}, 1'b0, 2'd0);
        check("R6", int'(grant_idx), 3);
        // R7 overrides a stalled preferred thread in sticky mode
        step(2'd1, 4'b1111, 4'b0010, '0, 1'b1, 2'd1);
        // R2: nothing usable in sticky mode
        step(2'd1, 4'b0011, 4'b0011, '0, 1'b0, 2'd0);
        // R11: pointer kept after empty cycle, rotate resumes after 1
        step(2'd0, 4'b1111, 4'b0000, '0, 1'b0, 2'd0);
        check("R11", int'(grant_idx), 2);

        // Sweeps over all modes, override off and on
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 2; p++) begin
                for (int s = 0; s < 400; s++) begin
                    logic [N-1:0] r;
                    logic [N-1:0] st;
                    logic [N*CNT_W-1:0] c;
                    lfsr = nxt(lfsr); r  = lfsr[3:0] | lfsr[7:4];
                    if (lfsr[11:8] == 4'd0) r = '0;
                    lfsr = nxt(lfsr); st = lfsr[3:0] & lfsr[9:6];
                    lfsr = nxt(lfsr); c  = {lfsr[11:0]} & {4{lfsr[15] ? 3'b011 : 3'b111}};
                    lfsr = nxt(lfsr);
                    step(2'(m), r, st, c, 1'(p), lfsr[1:0]);
                end
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule